// File: doc/BRIEF.md
# Row-Organised Custom-Operation Array

This block is a small grid of 32-bit functional units that runs one custom operation per request, from a configuration held in a local store. The grid has five rows (numbered 0 at the top to 4 at the bottom) with four units in each row. There are fourteen primary operands. Rows 0 to 4 receive 7, 2, 2, 2 and 1 of them. Each unit is configured with an opcode, two operand selects and a 16-bit immediate. A unit can take an operand from any of these sources:
- a primary operand of its own row;
- a unit in the row directly above;
- a unit reached over one of four fixed skip links: 0 to 2, 0 to 3, 0 to 4 and 1 to 3;
- its left or right neighbour, in rows 2 and 3 only;
- its own immediate.

All unit outputs are registered, and every unit is evaluated once per cycle. A dataflow graph with a longest path of D operations is therefore complete after D cycles. D (1 to 8) is stored in the configuration, and the response appears exactly D cycles after the request is taken. The response carries up to four selected unit outputs and a next program-counter value. That value is either a fall-through address or, when a configured branch unit reports true, a branch target.

The request side and the response side are valid/ready. A request is taken only when `req_ready` is high, which means the array is idle. `rsp_valid` holds, and the response data holds stable, until `rsp_ready` is seen high at a clock edge. No new request is taken before then. The configuration store is written one 32-bit word at a time. Writes are dropped while an operation is in flight or waiting to be taken.

Top module: `cfu_array`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and every configuration word is 0.
- R2: The unit opcode is in bits [3:0] of its word (word address = row*4 + column). The codes are:
  - 0: pass A
  - 1: A+B
  - 2: A-B
  - 3: AND
  - 4: OR
  - 5: XOR
  - 6: NOR
  - 7: A shifted left by B[4:0]
  - 8: logical right shift by B[4:0]
  - 9: arithmetic right shift by B[4:0]
  - 10: signed A<B as 0/1
  - 11: unsigned A<B as 0/1
  - 12: A==B as 0/1
  - 13: A!=B as 0/1

  Codes 14 and 15 give 0.
- R3: The select for operand A is in bits [8:4], and the select for operand B is in bits [13:9]. Select values 0 to 7 pick primary operand p of the unit's own row. Row r owns flat operands starting at index 0, 7, 9, 11 and 13 for rows 0 to 4. A p beyond the row's count yields 0. Select 22 picks the immediate in bits [31:16], sign-extended. Selects 23 to 31 yield 0.
- R4: Selects 8 to 11 pick unit 0 to 3 of the row above. Selects 12 to 15 pick unit 0 to 3 of row 0, for rows 2, 3 and 4. Selects 16 to 19 pick unit 0 to 3 of row 1, for row 3 only. Select 20 picks the left neighbour and select 21 the right neighbour, in rows 2 and 3 only. Any link a unit does not have yields 0.
- R5: The control word is at address 20, and its bits [3:0] give the depth D. `rsp_valid` rises exactly D cycles after the accepting edge. A stored value of 0 acts as 1, and values above 8 act as 8. A chain of D dependent operations is complete at that point.
- R6: While the response is pending, `req_ready` is 0, and `rsp_valid`, `rsp_result` and `rsp_next_pc` hold stable until `rsp_ready` is sampled high. On the edge after that, `req_ready` is 1 and `rsp_valid` is 0.
- R7: In the control word:
  - bit [4] enables the branch;
  - bits [9:5] name the branch unit;
  - bits [15:10] give a length L in words;
  - bits [31:16] give a signed word offset F.

  When the branch is enabled, the branch unit index is below 20, and bit 0 of that unit is 1, `rsp_next_pc` = pc + 4*F. Otherwise `rsp_next_pc` = pc + 4*L.
- R8: Word 21 selects the outputs. Result k (`rsp_result[32k+31:32k]`) is the output of the unit whose index is in bits [5k+4:5k]. An index of 20 or more gives 0.
- R9: A configuration write while `req_ready` is 0 has no effect. A write while `req_ready` is 1 takes effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_addr | input | 5 | Configuration word address (0-21) |
| cfg_wdata | input | 32 | Configuration word data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Array idle, request can be taken |
| req_pc | input | 32 | Program counter of the custom operation |
| req_opnd | input | 448 | Fourteen 32-bit primary operands, operand i at bits [32i+31:32i] |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_result | output | 128 | Four selected unit outputs |
| rsp_next_pc | output | 32 | Next program counter |

## Verification
The bench drives each request at a falling edge and treats the next rising edge as cycle 0. At each falling edge after cycles 0 to D-1 it checks that `rsp_valid` is still low. At the falling edge after cycle D it checks that `rsp_valid` is high, and only then reads the results and next-PC. Stall checks hold `rsp_ready` low for extra cycles and compare the held values at every falling edge. After the accepting edge of `rsp_ready`, the bench expects `req_ready` back one edge later. Blocked configuration writes are checked by the result of the next operation, and a checker counter ties the first `rsp_valid` cycle to the clamped depth.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  localparam int unsigned ROWS      = 5;
  localparam int unsigned UPR       = 4;
  localparam int unsigned NUNITS    = ROWS * UPR;
  localparam int unsigned NIN       = 14;
  localparam int unsigned CW        = 32;
  localparam int unsigned ADDR_CTRL = NUNITS;
  localparam int unsigned ADDR_OSEL = NUNITS + 1;
  localparam int unsigned CFG_WORDS = NUNITS + 2;
  localparam int unsigned AW        = $clog2(CFG_WORDS);
  localparam int unsigned MAX_DEPTH = 8;
  localparam int unsigned OSW       = 5;

  localparam logic [4:0] SEL_UP    = 5'd8;
  localparam logic [4:0] SEL_SKA   = 5'd12;
  localparam logic [4:0] SEL_SKB   = 5'd16;
  localparam logic [4:0] SEL_LEFT  = 5'd20;
  localparam logic [4:0] SEL_RIGHT = 5'd21;
  localparam logic [4:0] SEL_IMM   = 5'd22;

  typedef enum logic [3:0] {
    OP_PASS, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_SLL, OP_SRL, OP_SRA, OP_SLT, OP_SLTU, OP_EQ, OP_NE
  } op_e;

  typedef struct packed {
    logic [15:0] imm;
    logic [1:0]  rsvd;
    logic [4:0]  selb;
    logic [4:0]  sela;
    logic [3:0]  op;
  } ucfg_t;

  typedef struct packed {
    logic [15:0] br_off;
    logic [5:0]  len;
    logic [4:0]  br_unit;
    logic        br_en;
    logic [3:0]  depth;
  } ctrl_t;

  function automatic int unsigned row_cnt(int unsigned r);
    if (r == 0) return 7;
    if (r == ROWS - 1) return 1;
    return 2;
  endfunction

  function automatic int unsigned row_base(int unsigned r);
    int unsigned b;
    b = 0;
    for (int unsigned i = 0; i < r; i++) b += row_cnt(i);
    return b;
  endfunction
endpackage

// File: rtl/cfu_cfg_store.sv
module cfu_cfg_store
  import cfu_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [CW-1:0]                 wr_data,
  output logic [CFG_WORDS-1:0][CW-1:0]  words
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words <= '0;
    end else if (wr_en && (wr_addr < AW'(CFG_WORDS))) begin
      words[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/cfu_unit.sv
module cfu_unit
  import cfu_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned ROW = 0,
  parameter int unsigned COL = 0
) (
  input  ucfg_t                        cfg,
  input  logic [NIN-1:0][DW-1:0]       prim,
  input  logic [NUNITS-1:0][DW-1:0]    uq,
  output logic [DW-1:0]                y
);
  localparam int unsigned SHW   = $clog2(DW);
  localparam logic [4:0] NPRIM  = 5'(row_cnt(ROW));
  localparam logic [3:0] PBASE  = 4'(row_base(ROW));
  localparam bit HAS_UP  = (ROW > 0);
  localparam bit HAS_SKA = (ROW >= 2);
  localparam bit HAS_SKB = (ROW == 3);
  localparam bit HROW    = (ROW == 2) || (ROW == 3);
  localparam bit HAS_L   = HROW && (COL > 0);
  localparam bit HAS_R   = HROW && (COL < UPR - 1);
  localparam logic [4:0] UP_BASE  = HAS_UP ? 5'((ROW - 1) * UPR) : 5'd0;
  localparam logic [4:0] SKA_BASE = 5'd0;
  localparam logic [4:0] SKB_BASE = 5'(UPR);
  localparam logic [4:0] L_IDX    = HAS_L ? 5'(ROW * UPR + COL - 1) : 5'd0;
  localparam logic [4:0] R_IDX    = HAS_R ? 5'(ROW * UPR + COL + 1) : 5'd0;

  logic [1:0][DW-1:0] opv;
  logic [DW-1:0]      immx;
  logic [DW-1:0]      a, b;
  logic [SHW-1:0]     sh;

  assign immx = {{(DW-16){cfg.imm[15]}}, cfg.imm};

  always_comb begin
    logic [4:0] s;
    logic [3:0] pi;
    for (int k = 0; k < 2; k++) begin
      s      = (k == 0) ? cfg.sela : cfg.selb;
      pi     = PBASE + {1'b0, s[2:0]};
      opv[k] = '0;
      if (s < SEL_UP) begin
        if (s < NPRIM) opv[k] = prim[pi];
      end else if (s < SEL_SKA) begin
        if (HAS_UP) opv[k] = uq[UP_BASE + {3'b000, s[1:0]}];
      end else if (s < SEL_SKB) begin
        if (HAS_SKA) opv[k] = uq[SKA_BASE + {3'b000, s[1:0]}];
      end else if (s < SEL_LEFT) begin
        if (HAS_SKB) opv[k] = uq[SKB_BASE + {3'b000, s[1:0]}];
      end else if (s == SEL_LEFT) begin
        if (HAS_L) opv[k] = uq[L_IDX];
      end else if (s == SEL_RIGHT) begin
        if (HAS_R) opv[k] = uq[R_IDX];
      end else if (s == SEL_IMM) begin
        opv[k] = immx;
      end
    end
  end

  assign a  = opv[0];
  assign b  = opv[1];
  assign sh = b[SHW-1:0];

  always_comb begin
    case (cfg.op)
      OP_PASS: y = a;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOR:  y = ~(a | b);
      OP_SLL:  y = a << sh;
      OP_SRL:  y = a >> sh;
      OP_SRA:  y = $unsigned($signed(a) >>> sh);
      OP_SLT:  y = {{(DW-1){1'b0}}, $signed(a) < $signed(b)};
      OP_SLTU: y = {{(DW-1){1'b0}}, a < b};
      OP_EQ:   y = {{(DW-1){1'b0}}, a == b};
      OP_NE:   y = {{(DW-1){1'b0}}, a != b};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/cfu_seq.sv
module cfu_seq
  import cfu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       rsp_ready,
  input  logic [3:0] depth,
  output logic       req_ready,
  output logic       rsp_valid,
  output logic       run_en
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_e;
  st_e        st;
  logic [3:0] cnt;
  logic [3:0] deff;

  always_comb begin
    if (depth == 4'd0)                deff = 4'd1;
    else if (depth > 4'(MAX_DEPTH))   deff = 4'(MAX_DEPTH);
    else                              deff = depth;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st  <= S_RUN;
          cnt <= 4'd1;
        end
        S_RUN: begin
          if (cnt == deff) st <= S_DONE;
          else             cnt <= cnt + 4'd1;
        end
        S_DONE: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_DONE);
  assign run_en    = (st == S_RUN);
endmodule

// File: rtl/cfu_array.sv
module cfu_array
  import cfu_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned NUM_OUT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [AW-1:0]           cfg_addr,
  input  logic [CW-1:0]           cfg_wdata,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [DW-1:0]           req_pc,
  input  logic [NIN*DW-1:0]       req_opnd,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [NUM_OUT*DW-1:0]   rsp_result,
  output logic [DW-1:0]           rsp_next_pc
);
  logic [CFG_WORDS-1:0][CW-1:0] cfg_words;
  logic [NIN-1:0][DW-1:0]       opnd_q;
  logic [NUNITS-1:0][DW-1:0]    uq, ud;
  logic [DW-1:0]                pc_q;
  logic                         run_en, accept, taken;
  ctrl_t                        ctrl;

  assign accept = req_valid && req_ready;
  assign ctrl   = ctrl_t'(cfg_words[ADDR_CTRL]);

  cfu_cfg_store u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we && req_ready), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .words(cfg_words)
  );

  cfu_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_ready(rsp_ready),
    .depth(ctrl.depth), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .run_en(run_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opnd_q <= '0;
      pc_q   <= '0;
      uq     <= '0;
    end else begin
      if (accept) begin
        opnd_q <= req_opnd;
        pc_q   <= req_pc;
      end
      if (run_en) uq <= ud;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < UPR; c++) begin : g_col
      cfu_unit #(.DW(DW), .ROW(r), .COL(c)) u_unit (
        .cfg(ucfg_t'(cfg_words[r*UPR+c])),
        .prim(opnd_q),
        .uq(uq),
        .y(ud[r*UPR+c])
      );
    end
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [OSW-1:0] os;
    assign os = cfg_words[ADDR_OSEL][o*OSW +: OSW];
    assign rsp_result[o*DW +: DW] = (os < OSW'(NUNITS)) ? uq[os] : '0;
  end

  assign taken = ctrl.br_en && (ctrl.br_unit < 5'(NUNITS)) && uq[ctrl.br_unit][0];
  assign rsp_next_pc = taken
    ? pc_q + {{(DW-18){ctrl.br_off[15]}}, ctrl.br_off, 2'b00}
    : pc_q + {{(DW-8){1'b0}}, ctrl.len, 2'b00};
endmodule

// File: rtl/cfu_array_checker.sv
module cfu_array_checker
  import cfu_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned NUM_OUT = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_valid,
  input logic                         req_ready,
  input logic                         rsp_valid,
  input logic                         rsp_ready,
  input logic [NUM_OUT*DW-1:0]        rsp_result,
  input logic [DW-1:0]                rsp_next_pc,
  input logic [CFG_WORDS-1:0][CW-1:0] cfg_words,
  input logic [DW-1:0]                pc_q
);
  ctrl_t      c;
  logic [3:0] lat, dexp;

  assign c = ctrl_t'(cfg_words[ADDR_CTRL]);
  assign dexp = (c.depth == 4'd0) ? 4'd1 : ((c.depth > 4'd8) ? 4'd8 : c.depth);

  always_ff @(posedge clk) begin
    if (!rst_n) lat <= '0;
    else if (req_valid && req_ready) lat <= '0;
    else if (!req_ready && !rsp_valid && lat != 4'hF) lat <= lat + 4'd1;
  end

  assert_resp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_result) && $stable(rsp_next_pc));

  assert_ready_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(cfg_words));

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> lat == dexp);

  assert_lat_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lat <= 4'd8);

  assert_fallthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !c.br_en |-> rsp_next_pc == pc_q + {{(DW-8){1'b0}}, c.len, 2'b00});
endmodule

bind cfu_array cfu_array_checker #(.DW(DW), .NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_result(rsp_result),
  .rsp_next_pc(rsp_next_pc), .cfg_words(cfg_words), .pc_q(pc_q)
);

// File: tb/cfu_array_bench.sv
module cfu_array_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_we;
  logic [4:0]   cfg_addr;
  logic [31:0]  cfg_wdata;
  logic         req_valid, req_ready, rsp_valid, rsp_ready;
  logic [31:0]  req_pc, rsp_next_pc;
  logic [447:0] req_opnd;
  logic [127:0] rsp_result;
  logic [31:0]  opw [14];
  logic [31:0]  got [4];
  logic [31:0]  got_pc;
  int           n_vec = 0, n_bad = 0;
  logic [31:0]  rs = 32'h1234_5678;

  always #4 clk = ~clk;

  always_comb for (int k = 0; k < 14; k++) req_opnd[k*32 +: 32] = opw[k];

  cfu_array u_cfu_array (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_pc(req_pc), .req_opnd(req_opnd), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_result(rsp_result), .rsp_next_pc(rsp_next_pc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
    return rs;
  endfunction

  function automatic logic [31:0] ucw(input int op, input int sa, input int sb, input logic [15:0] imm);
    return {imm, 2'b00, 5'(sb), 5'(sa), 4'(op)};
  endfunction

  function automatic logic [31:0] ctw(input int d, input bit be, input int bu, input int len, input logic [15:0] off);
    return {off, 6'(len), 5'(bu), be, 4'(d)};
  endfunction

  function automatic logic [31:0] osw(input int o0, input int o1, input int o2, input int o3);
    return {12'd0, 5'(o3), 5'(o2), 5'(o1), 5'(o0)};
  endfunction

  function automatic logic [31:0] ref_alu(input int op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      0: return a;
      1: return a + b;
      2: return a - b;
      3: return a & b;
      4: return a | b;
      5: return a ^ b;
      6: return ~(a | b);
      7: return a << b[4:0];
      8: return a >> b[4:0];
      9: return $unsigned($signed(a) >>> b[4:0]);
      10: return {31'd0, $signed(a) < $signed(b)};
      11: return {31'd0, a < b};
      12: return {31'd0, a == b};
      13: return {31'd0, a != b};
      default: return 32'd0;
    endcase
  endfunction

  function automatic int rbase(input int r);
    case (r) 0: return 0; 1: return 7; 2: return 9; 3: return 11; default: return 13; endcase
  endfunction

  function automatic int rcnt(input int r);
    return (r == 0) ? 7 : ((r == 4) ? 1 : 2);
  endfunction

  task automatic cw(input int addr, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_cfg();
    for (int a = 0; a < 22; a++) cw(a, 32'd0);
  endtask

  task automatic invoke(input logic [31:0] pc, input int d, input int hold);
    @(negedge clk);
    chk("R6 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_pc = pc; rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < d; k++) begin
      chk("R5 not yet valid", 32'(rsp_valid), 32'd0);
      @(negedge clk);
    end
    chk("R5 valid at depth", 32'(rsp_valid), 32'd1);
    for (int k = 0; k < 4; k++) got[k] = rsp_result[k*32 +: 32];
    got_pc = rsp_next_pc;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R6 valid held", 32'(rsp_valid), 32'd1);
      chk("R6 ready low while pending", 32'(req_ready), 32'd0);
      chk("R6 result held", rsp_result[31:0], got[0]);
      chk("R6 pc held", rsp_next_pc, got_pc);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R6 ready after take", 32'(req_ready), 32'd1);
    chk("R6 valid dropped", 32'(rsp_valid), 32'd0);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] pa [8];
    logic [31:0] pb [8];
    logic [31:0] v [20];
    logic [31:0] e;
    int src, d;
    pa = '{32'h8000_0001, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0, 32'h7, 32'h7FFF_FFFF, 32'h8000_0000, 32'hDEAD_BEEF};
    pb = '{32'h1, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0, 32'd31, 32'h8000_0000, 32'd32, 32'h4};
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; rsp_ready = 1'b0; req_pc = '0;
    for (int k = 0; k < 14; k++) opw[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready after reset", 32'(req_ready), 32'd1);
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    invoke(32'h100, 1, 0);
    chk("R1 zero config result", got[0], 32'd0);
    chk("R1 zero config next pc", got_pc, 32'h100);

    // R2 opcode sweep on unit 0, R8 unused output index reads zero
    cw(21, osw(0, 31, 20, 31));
    cw(20, ctw(1, 0, 0, 3, 16'h0));
    for (int op = 0; op < 16; op++) begin
      cw(0, ucw(op, 0, 1, 16'h0));
      for (int p = 0; p < 8; p++) begin
        opw[0] = pa[p]; opw[1] = pb[p];
        invoke(32'h4000, 1, 0);
        chk($sformatf("R2 op %0d pair %0d", op, p), got[0], ref_alu(op, pa[p], pb[p]));
        chk("R8 out-of-range select", got[1], 32'd0);
        chk("R7 fall-through", got_pc, 32'h400C);
      end
    end

    // R3 primary-operand distribution and immediate
    for (int k = 0; k < 14; k++) opw[k] = 32'h100 + 32'(k) * 32'h11;
    for (int r = 0; r < 5; r++) begin
      cw(21, osw(r*4, 31, 31, 31));
      for (int s = 0; s < 8; s++) begin
        cw(r*4, ucw(0, s, 0, 16'h0));
        invoke(32'h0, 1, 0);
        e = (s < rcnt(r)) ? opw[rbase(r) + s] : 32'd0;
        chk($sformatf("R3 row %0d sel %0d", r, s), got[0], e);
      end
      cw(r*4, ucw(0, 22, 0, 16'h8001));
      invoke(32'h0, 1, 0);
      chk("R3 immediate negative", got[0], 32'hFFFF_8001);
      cw(r*4, ucw(1, 22, 0, 16'h1234));
      invoke(32'h0, 1, 0);
      chk("R3 immediate plus operand", got[0], 32'h1234 + opw[rbase(r)]);
      cw(r*4, ucw(0, 25, 0, 16'h1234));
      invoke(32'h0, 1, 0);
      chk("R3 unused select zero", got[0], 32'd0);
    end

    // R4 links: every unit base = row operand 0 + (index+1)
    cw(20, ctw(2, 0, 0, 1, 16'h0));
    for (int u = 0; u < 20; u++) begin
      cw(u, ucw(1, 0, 22, 16'(u + 1)));
      v[u] = opw[rbase(u / 4)] + 32'(u + 1);
    end
    for (int r = 0; r < 5; r++) begin
      for (int j = 0; j < 4; j++) begin
        cw(21, osw(r*4 + j, 31, 31, 31));
        for (int s = 8; s < 22; s++) begin
          src = -1;
          if (s < 12)      begin if (r > 0) src = (r-1)*4 + (s-8); end
          else if (s < 16) begin if (r >= 2) src = s-12; end
          else if (s < 20) begin if (r == 3) src = 4 + (s-16); end
          else if (s == 20) begin if ((r == 2 || r == 3) && j > 0) src = r*4 + j - 1; end
          else begin if ((r == 2 || r == 3) && j < 3) src = r*4 + j + 1; end
          cw(r*4 + j, ucw(0, s, 0, 16'h0));
          invoke(32'h0, 2, 0);
          e = (src < 0) ? 32'd0 : v[src];
          chk($sformatf("R4 unit %0d sel %0d", r*4 + j, s), got[0], e);
        end
        cw(r*4 + j, ucw(1, 0, 22, 16'(r*4 + j + 1)));
      end
    end

    // R5 depth sweep with clamping
    clear_cfg();
    cw(0, ucw(1, 0, 1, 16'h0));
    cw(21, osw(0, 31, 31, 31));
    opw[0] = 32'd40; opw[1] = 32'd2;
    for (int dd = 0; dd < 16; dd++) begin
      cw(20, ctw(dd, 0, 0, 2, 16'h0));
      d = (dd == 0) ? 1 : ((dd > 8) ? 8 : dd);
      invoke(32'h200, d, 0);
      chk($sformatf("R5 depth %0d result", dd), got[0], 32'd42);
    end

    // R6 back-pressure
    invoke(32'h200, 8, 5);
    chk("R6 result after stall", got[0], 32'd42);

    // R4 R7 R8 eight-level chain across every link kind
    clear_cfg();
    cw(0,  ucw(1, 0, 1, 16'h0));
    cw(1,  ucw(3, 2, 3, 16'h0));
    cw(3,  ucw(0, 22, 0, 16'hFFF0));
    cw(4,  ucw(1, 8, 0, 16'h0));
    cw(8,  ucw(5, 8, 13, 16'h0));
    cw(9,  ucw(7, 20, 22, 16'h3));
    cw(13, ucw(2, 9, 16, 16'h0));
    cw(12, ucw(0, 21, 0, 16'h0));
    cw(14, ucw(1, 20, 0, 16'h0));
    cw(15, ucw(5, 20, 15, 16'h0));
    cw(19, ucw(11, 11, 0, 16'h0));
    cw(21, osw(15, 13, 12, 19));
    cw(20, ctw(8, 1, 19, 6, 16'hFFF8));
    for (int t = 0; t < 24; t++) begin
      logic [31:0] u0, u1, u4, u8, u9, u13, u14, u15, u19, pc;
      for (int k = 0; k < 14; k++) opw[k] = rnd();
      opw[13] = (t % 2 == 0) ? 32'd0 : ((t % 4 == 1) ? 32'hFFFF_FFFF : rnd());
      pc = {rnd() & 32'h00FF_FFFC};
      u0 = opw[0] + opw[1]; u1 = opw[2] & opw[3]; u4 = u0 + opw[7];
      u8 = u4 ^ u1; u9 = u8 << 3; u13 = u9 - u4; u14 = u13 + opw[11];
      u15 = u14 ^ 32'hFFFF_FFF0; u19 = {31'd0, u15 < opw[13]};
      invoke(pc, 8, 0);
      chk("R4 chain unit 15", got[0], u15);
      chk("R4 chain skip/vertical unit 13", got[1], u13);
      chk("R4 right neighbour unit 12", got[2], u13);
      chk("R8 chain compare output", got[3], u19);
      chk("R7 branch next pc", got_pc, u19[0] ? pc - 32'd32 : pc + 32'd24);
    end
    opw[13] = 32'hFFFF_FFFF; opw[0] = 32'd1; opw[1] = 32'd0;
    cw(20, ctw(8, 0, 19, 5, 16'hFFF8));
    invoke(32'h1000, 8, 0);
    chk("R7 no branch uses length", got_pc, 32'h1014);
    cw(20, ctw(8, 1, 25, 5, 16'hFFF8));
    invoke(32'h1000, 8, 0);
    chk("R7 branch unit out of range", got_pc, 32'h1014);

    // R9 configuration writes blocked while busy
    clear_cfg();
    cw(0, ucw(1, 0, 1, 16'h0));
    cw(21, osw(0, 31, 31, 31));
    cw(20, ctw(4, 0, 0, 1, 16'h0));
    opw[0] = 32'd9; opw[1] = 32'd4;
    @(negedge clk);
    req_valid = 1'b1; req_pc = 32'h0;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = 5'd0; cfg_wdata = ucw(2, 0, 1, 16'h0);
    @(negedge clk);
    cfg_addr = 5'd20; cfg_wdata = ctw(1, 0, 0, 1, 16'h0);
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 result valid at depth 4", 32'(rsp_valid), 32'd1);
    chk("R9 busy write ignored in flight", rsp_result[31:0], 32'd13);
    cfg_we = 1'b1; cfg_addr = 5'd0; cfg_wdata = ucw(3, 0, 1, 16'h0);
    @(negedge clk);
    cfg_we = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    invoke(32'h0, 4, 0);
    chk("R9 busy writes left config intact", got[0], 32'd13);
    cw(0, ucw(2, 0, 1, 16'h0));
    invoke(32'h0, 4, 0);
    chk("R9 idle write takes effect", got[0], 32'd5);

    finish_run();
  end
endmodule